// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block decides which of five interrupt sources a small controller core serves next. It holds a source-enable register with a master enable, and a priority register that puts each source at the low or the high level. It compares pending requests against these registers and against what is already in service. When the core signals an instruction boundary and a request may run, the block emits a one-cycle take pulse carrying a fixed vector address. The core answers that pulse by saving its program counter and jumping to the vector.

Two in-service flags record how deep the service nesting is. A high-level request can interrupt a low-level handler. Nothing interrupts a high-level handler, and nothing interrupts a handler of its own level. The core's return-from-interrupt strobe closes the innermost open level. Timers and the serial unit are not part of the block; they only drive request lines.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, `take` is 0 and `in_service` is 00. All enable and priority bits are clear, so no request is taken until the enable register is written.
- R2: The enable register is written with `en_we`/`en_wdata`. Bits 4..0 enable the sources one by one and bit 5 is the master enable. A source is taken only when its own bit and bit 5 are both 1.
- R3: Requests are evaluated only on a clock edge where `insn_bnd` is 1. The resulting `take` pulse appears in the following cycle and lasts one cycle. Each boundary produces at most one take.
- R4: Source index on `irq_req`: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial. The vector on `take_vec` is 0x0003 + 8 × index, giving 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R5: The priority register is written with `pri_we`/`pri_wdata`, where bit i = 1 puts source i at the high level. An eligible high-level request always wins over a low-level one, whatever their indices.
- R6: Among eligible requests of the same level, the lowest index wins.
- R7: While only a low-level handler is in service (`in_service` = 01), an enabled high-level request is taken and `in_service` becomes 11.
- R8: No request is taken while the high flag is set. No low-level request is taken while any flag is set.
- R9: A take sets the `in_service` bit of the granted level (bit 0 low, bit 1 high). A `reti` clears the highest set bit, and clears nothing when both bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 5 | Request lines, one per source |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 6 | Enable data: bits 4..0 per source, bit 5 master enable |
| pri_we | input | 1 | Write strobe for the priority register |
| pri_wdata | input | 5 | Priority data, 1 = high level |
| insn_bnd | input | 1 | Core is at an instruction boundary |
| reti | input | 1 | Core executed a return from interrupt |
| take | output | 1 | One-cycle interrupt take pulse |
| take_vec | output | 16 | Vector address of the last take |
| in_service | output | 2 | In-service flags {high, low} |

## Verification
A wrong in-service flag shows at the ports on the next boundary that has a request pending. A flag that is wrongly set suppresses a take that should happen. A flag that is wrongly clear lets a same-level request through, which is a nested take that R8 forbids. A flipped priority comparison or a broken tie order shows in the same cycle as the take, as a wrong `take_vec`. A stale or lost enable write shows as a missing or extra `take` one cycle after the next boundary.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
   // service levels
   typedef enum logic {
      LVL_LOW  = 1'b0,
      LVL_HIGH = 1'b1
   } ivc_level_e;

   localparam int IVC_LEVELS = 2;
endpackage

// File: rtl/ivc_cfg_regs.sv
module ivc_cfg_regs #(
   parameter int NSRC = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en_we,
   input  logic [NSRC:0]   en_wdata,
   input  logic            pri_we,
   input  logic [NSRC-1:0] pri_wdata,
   output logic [NSRC:0]   en_q,
   output logic [NSRC-1:0] pri_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         pri_q <= '0;
      end else begin
         if (en_we)  en_q  <= en_wdata;
         if (pri_we) pri_q <= pri_wdata;
      end
   end
endmodule

// File: rtl/ivc_first_one.sv
module ivc_first_one #(
   parameter int N     = 5,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     vec_in,
   output logic             vld,
   output logic [IDX_W-1:0] idx
);
   // lowest set index wins: scan downward so the last hit is the lowest
   always_comb begin
      vld = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_in[i]) begin
            vld = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
   import ivc_pkg::*;
#(
   parameter int NSRC  = 5,
   parameter int IDX_W = 3
) (
   input  logic [NSRC-1:0]  req,
   input  logic [NSRC:0]    en_q,
   input  logic [NSRC-1:0]  pri_q,
   input  logic [1:0]       ins,
   output logic             grant_vld,
   output ivc_level_e       grant_lvl,
   output logic [IDX_W-1:0] grant_idx
);
   logic [NSRC-1:0]  elig [IVC_LEVELS];
   logic             lvl_vld [IVC_LEVELS];
   logic [IDX_W-1:0] lvl_idx [IVC_LEVELS];
   logic             open_hi, open_lo;

   // a level accepts work only if nothing at or above it is in service
   assign open_hi = ~ins[1];
   assign open_lo = (ins == 2'b00);

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      logic armed;
      assign armed          = req[s] & en_q[s] & en_q[NSRC];
      assign elig[1][s]     = armed &  pri_q[s] & open_hi;
      assign elig[0][s]     = armed & ~pri_q[s] & open_lo;
   end

   for (genvar l = 0; l < IVC_LEVELS; l++) begin : g_lvl
      ivc_first_one #(.N(NSRC), .IDX_W(IDX_W)) u_pick (
         .vec_in (elig[l]),
         .vld    (lvl_vld[l]),
         .idx    (lvl_idx[l])
      );
   end

   always_comb begin
      grant_vld = lvl_vld[1] | lvl_vld[0];
      if (lvl_vld[1]) begin
         grant_lvl = LVL_HIGH;
         grant_idx = lvl_idx[1];
      end else begin
         grant_lvl = LVL_LOW;
         grant_idx = lvl_idx[0];
      end
   end
endmodule

// File: rtl/ivc_service_track.sv
module ivc_service_track
   import ivc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take_now,
   input  ivc_level_e take_lvl,
   input  logic       reti,
   output logic [1:0] ins
);
   logic [1:0] after_ret, ins_d;

   always_comb begin
      after_ret = ins;
      if (reti) begin
         if (ins[1]) after_ret[1] = 1'b0;
         else        after_ret[0] = 1'b0;
      end
      ins_d = after_ret;
      if (take_now) ins_d[take_lvl] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ins <= '0;
      else        ins <= ins_d;
   end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
   import ivc_pkg::*;
#(
   parameter int NSRC       = 5,
   parameter int VEC_W      = 16,
   parameter int VEC_BASE   = 3,
   parameter int VEC_STRIDE = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  irq_req,
   input  logic             en_we,
   input  logic [NSRC:0]    en_wdata,
   input  logic             pri_we,
   input  logic [NSRC-1:0]  pri_wdata,
   input  logic             insn_bnd,
   input  logic             reti,
   output logic             take,
   output logic [VEC_W-1:0] take_vec,
   output logic [1:0]       in_service
);
   localparam int IDX_W   = (NSRC > 1) ? $clog2(NSRC) : 1;
   localparam int VEC_TOP = VEC_BASE + (NSRC - 1) * VEC_STRIDE;

   if (NSRC < 1 || NSRC > 16) begin : g_bad_nsrc
      $error("irq_vec_ctrl: NSRC out of range");
   end
   if (VEC_STRIDE < 1) begin : g_bad_stride
      $error("irq_vec_ctrl: VEC_STRIDE must be positive");
   end
   if (VEC_TOP >= (1 << VEC_W)) begin : g_bad_width
      $error("irq_vec_ctrl: vector table does not fit VEC_W");
   end

   logic [NSRC:0]    en_q;
   logic [NSRC-1:0]  pri_q;
   logic             grant_vld;
   ivc_level_e       grant_lvl;
   logic [IDX_W-1:0] grant_idx;
   logic             take_now;

   ivc_cfg_regs #(.NSRC(NSRC)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_we     (en_we),
      .en_wdata  (en_wdata),
      .pri_we    (pri_we),
      .pri_wdata (pri_wdata),
      .en_q      (en_q),
      .pri_q     (pri_q)
   );

   ivc_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
      .req       (irq_req),
      .en_q      (en_q),
      .pri_q     (pri_q),
      .ins       (in_service),
      .grant_vld (grant_vld),
      .grant_lvl (grant_lvl),
      .grant_idx (grant_idx)
   );

   assign take_now = insn_bnd & grant_vld;

   ivc_service_track u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_now (take_now),
      .take_lvl (grant_lvl),
      .reti     (reti),
      .ins      (in_service)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take     <= 1'b0;
         take_vec <= '0;
      end else begin
         take <= take_now;
         if (take_now)
            take_vec <= VEC_W'(VEC_BASE) + VEC_W'(grant_idx) * VEC_W'(VEC_STRIDE);
      end
   end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
   parameter int NSRC       = 5,
   parameter int VEC_W      = 16,
   parameter int VEC_BASE   = 3,
   parameter int VEC_STRIDE = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             insn_bnd,
   input logic             reti,
   input logic             take,
   input logic [VEC_W-1:0] take_vec,
   input logic [1:0]       in_service
);
   localparam int VEC_END = VEC_BASE + NSRC * VEC_STRIDE;

   // R3: a take follows a boundary sampled on the previous edge
   p_take_after_bnd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> $past(insn_bnd));

   // R4: vector lies on the table grid
   p_vec_on_grid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> ((int'(take_vec) >= VEC_BASE) && (int'(take_vec) < VEC_END) &&
                ((int'(take_vec) - VEC_BASE) % VEC_STRIDE == 0)));

   // R8: nothing is taken while a high-level handler runs
   p_no_nest_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_service[1] |=> !take);

   // R9: a take always leaves some level in service
   p_take_marks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (in_service != 2'b00));

   // R9: return from the doubly nested state drops the high flag
   p_reti_high_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && in_service == 2'b11) |=> (in_service == 2'b01));

   // R7: the high flag only rises with a take
   p_high_rise_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_service[1]) |-> take);
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(
   .NSRC(NSRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .insn_bnd   (insn_bnd),
   .reti       (reti),
   .take       (take),
   .take_vec   (take_vec),
   .in_service (in_service)
);

// File: tb/irq_vec_ctrl_test.sv
`timescale 1ns/1ps
module irq_vec_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  irq_req = '0;
   logic        en_we = 1'b0;
   logic [5:0]  en_wdata = '0;
   logic        pri_we = 1'b0;
   logic [4:0]  pri_wdata = '0;
   logic        insn_bnd = 1'b0;
   logic        reti = 1'b0;
   logic        take;
   logic [15:0] take_vec;
   logic [1:0]  in_service;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference state
   logic [5:0]  m_en = '0;
   logic [4:0]  m_pri = '0;
   logic [1:0]  m_ins = '0;
   logic        m_take = 1'b0;
   logic [15:0] m_vec = '0;

   always #2.5 clk = ~clk;

   irq_vec_ctrl uut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
      .en_we(en_we), .en_wdata(en_wdata),
      .pri_we(pri_we), .pri_wdata(pri_wdata),
      .insn_bnd(insn_bnd), .reti(reti),
      .take(take), .take_vec(take_vec), .in_service(in_service)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // returns -1 for no grant, else index + 8*level
   function automatic int pick(input logic [4:0] rq, input logic [5:0] en,
                               input logic [4:0] pr, input logic [1:0] ins);
      int r = -1;
      if (en[5]) begin
         if (!ins[1])
            for (int i = 4; i >= 0; i--) if (rq[i] && en[i] && pr[i]) r = 8 + i;
         if (r < 0 && ins == 2'b00)
            for (int i = 4; i >= 0; i--) if (rq[i] && en[i] && !pr[i]) r = i;
      end
      return r;
   endfunction

   task automatic step(input logic [4:0] rq, input bit bnd, input bit ret,
                       input bit ewe, input logic [5:0] ed,
                       input bit pwe, input logic [4:0] pd, input string tag);
      int g;
      irq_req = rq; insn_bnd = bnd; reti = ret;
      en_we = ewe; en_wdata = ed; pri_we = pwe; pri_wdata = pd;
      @(posedge clk);
      g = pick(rq, m_en, m_pri, m_ins);
      m_take = bnd && (g >= 0);
      if (m_take) m_vec = 16'(3 + 8 * (g % 8));
      if (ret) begin
         if (m_ins[1]) m_ins[1] = 1'b0; else m_ins[0] = 1'b0;
      end
      if (m_take) m_ins[g / 8] = 1'b1;
      if (ewe) m_en = ed;
      if (pwe) m_pri = pd;
      @(negedge clk);
      check(tag, 32'(take), 32'(m_take));
      check(tag, 32'(in_service), 32'(m_ins));
      if (m_take) check(tag, 32'(take_vec), 32'(m_vec));
      irq_req = '0; insn_bnd = 1'b0; reti = 1'b0; en_we = 1'b0; pri_we = 1'b0;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      check("R1", 32'(take), 32'd0);
      check("R1", 32'(in_service), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 32'(take), 32'd0);
      check("R1", 32'(in_service), 32'd0);
      step(5'h1F, 1, 0, 0, '0, 0, '0, "R1");
      check("R1", 32'(take), 32'd0);

      // R2: local without master, then master without locals
      step(5'h00, 0, 0, 1, 6'h1F, 0, '0, "R2");
      step(5'h1F, 1, 0, 0, '0, 0, '0, "R2");
      check("R2", 32'(take), 32'd0);
      step(5'h00, 0, 0, 1, 6'h20, 0, '0, "R2");
      step(5'h1F, 1, 0, 0, '0, 0, '0, "R2");
      check("R2", 32'(take), 32'd0);
      step(5'h00, 0, 0, 1, 6'h3F, 0, '0, "R2");

      // R3: no boundary, no take
      step(5'h1F, 0, 0, 0, '0, 0, '0, "R3");
      check("R3", 32'(take), 32'd0);
      step(5'h1F, 0, 0, 0, '0, 0, '0, "R3");
      check("R3", 32'(take), 32'd0);

      // R6/R4: all low, lowest index wins
      step(5'h1F, 1, 0, 0, '0, 0, '0, "R6");
      check("R6", 32'(take_vec), 32'h0003);
      check("R9", 32'(in_service), 32'h1);
      step(5'h00, 0, 0, 0, '0, 0, '0, "R3");
      check("R3", 32'(take), 32'd0);
      step(5'h00, 0, 1, 0, '0, 0, '0, "R9");
      check("R9", 32'(in_service), 32'h0);
      step(5'h00, 0, 1, 0, '0, 0, '0, "R9");
      check("R9", 32'(in_service), 32'h0);

      // R5: serial high beats everything low
      step(5'h00, 0, 0, 0, '0, 1, 5'h10, "R5");
      step(5'h1F, 1, 0, 0, '0, 0, '0, "R5");
      check("R5", 32'(take_vec), 32'h0023);
      check("R5", 32'(in_service), 32'h2);
      step(5'h1F, 1, 0, 0, '0, 0, '0, "R8");
      check("R8", 32'(take), 32'd0);
      step(5'h00, 0, 1, 0, '0, 0, '0, "R9");

      // R7: low timer 0 in service, then high timer 1 preempts
      step(5'h00, 0, 0, 0, '0, 1, 5'h00, "R4");
      step(5'h02, 1, 0, 0, '0, 0, '0, "R4");
      check("R4", 32'(take_vec), 32'h000B);
      step(5'h1D, 1, 0, 0, '0, 0, '0, "R8");
      check("R8", 32'(take), 32'd0);
      step(5'h00, 0, 0, 0, '0, 1, 5'h08, "R7");
      step(5'h09, 1, 0, 0, '0, 0, '0, "R7");
      check("R7", 32'(take_vec), 32'h001B);
      check("R7", 32'(in_service), 32'h3);
      step(5'h1F, 1, 0, 0, '0, 0, '0, "R8");
      check("R8", 32'(take), 32'd0);
      step(5'h00, 0, 1, 0, '0, 0, '0, "R9");
      check("R9", 32'(in_service), 32'h1);
      step(5'h00, 0, 1, 0, '0, 0, '0, "R9");
      check("R9", 32'(in_service), 32'h0);
      // R4: external 1 vector
      step(5'h04, 1, 0, 0, '0, 0, '0, "R4");
      check("R4", 32'(take_vec), 32'h0013);
      step(5'h00, 0, 1, 0, '0, 0, '0, "R9");

      // constrained random mix
      for (int k = 0; k < 4000; k++) begin
         logic [5:0] ed;
         ed = 6'($urandom);
         if ($urandom % 4 != 0) ed[5] = 1'b1;
         step(5'($urandom), bit'($urandom % 2), ($urandom % 5) == 0,
              ($urandom % 25) == 0, ed, ($urandom % 25) == 0, 5'($urandom), "R6");
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule